// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

The compositor merges four rectangular image layers into a single RGB pixel stream for a raster display. Each clock it receives the current raster column and row, one ARGB8888 pixel from every layer in parallel, and a static set of layer settings. Each setting group holds an enable, a screen rectangle, a priority, a pipe number and an optional global alpha. The block works out which layers cover the current screen position and returns the composited colour a fixed number of cycles later.

Composition happens in two steps. First, each of the two pipes picks the single covering layer with the highest priority among the layers assigned to it. Second, the lower pipe (pipe 0) is blended over a programmable background colour, and the upper pipe (pipe 1) is then blended over that result. Each step uses the effective alpha of the pixel that was picked. A mode input reproduces a known hardware flaw: the lowest-priority layer of pipe 0 shows only the background wherever it carries any transparency. Fetching pixels from memory, format conversion and scaling are done upstream of this block.

Top module: `lcomp_top`

## Requirements
- R1: Each of the four layers has its own enable bit (`lay_en[i]`). A disabled layer never affects the output, whatever its pixel and rectangle settings are.
- R2: `lay_pipe[i]` places layer i on pipe 0 (value 0, the lower pipe) or on pipe 1 (value 1, the upper pipe). The upper pipe is always blended on top of the lower pipe.
- R3: Among the enabled layers on one pipe that cover the current position, the pipe outputs the pixel of the layer with the largest 2-bit priority value (`lay_prio[2i+1:2i]`). When two such layers have equal priority, the lower layer index wins.
- R4: Layer i covers the position (x, y) when xpos ≤ x < xpos+width and ypos ≤ y < ypos+height. The positions are 12-bit two's-complement values, so a layer that is partly off-screen is clipped. A width or height of 0 covers nothing.
- R5: Pixel fields are alpha [31:24], red [23:16], green [15:8] and blue [7:0]. When `lay_gaen[i]` is 1, the effective alpha is round(a·g/255) with g = `lay_galpha` bits [15:8] of the layer's 16-bit field, where round(v/255) means floor((v+127)/255). When `lay_gaen[i]` is 0, the effective alpha is the pixel's own alpha.
- R6: Each blend computes, per channel, out = floor((a·top + (255−a)·bottom + 127)/255). Pipe 0's pixel is blended over the background, and pipe 1's pixel is then blended over that result.
- R7: Where no enabled layer covers the position, the output equals `bg_rgb` (red [23:16], green [15:8], blue [7:0]).
- R8: When `low_alpha_drop` is 1 and the pixel picked by pipe 0 comes from the lowest-priority enabled layer on pipe 0, that pixel is replaced by opaque background colour if its effective alpha is below 255. Ties for lowest priority go to the higher index. Pixels from other layers are unaffected. When `low_alpha_drop` is 0, nothing is replaced.
- R9: While `rst_n` is low, `out_rgb` is 0 (black).
- R10: `out_rgb` reflects the inputs that were sampled two rising clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_x | input | 11 | Current raster column |
| ras_y | input | 11 | Current raster row |
| bg_rgb | input | 24 | Background colour |
| low_alpha_drop | input | 1 | Enables the lowest-pipe-0-layer alpha flaw |
| lay_en | input | 4 | Per-layer enable |
| lay_pipe | input | 4 | Per-layer pipe number |
| lay_prio | input | 8 | Per-layer 2-bit priority |
| lay_gaen | input | 4 | Per-layer global alpha enable |
| lay_galpha | input | 64 | Per-layer 16-bit global alpha |
| lay_xpos | input | 48 | Per-layer signed 12-bit column |
| lay_ypos | input | 48 | Per-layer signed 12-bit row |
| lay_w | input | 44 | Per-layer 11-bit width |
| lay_h | input | 44 | Per-layer 11-bit height |
| lay_argb | input | 128 | Per-layer ARGB8888 pixel |
| out_rgb | output | 24 | Composited RGB pixel |

## Verification
The assertions assume that the layer settings and the background colour are steady across the two pipeline cycles they relate. For example, the background check compares the output with the background from two edges earlier, and it does so only while every layer has stayed disabled. The stimulus changes settings only at falling edges and then holds them for at least two rising edges before the output is sampled. The raster position is moved only through single points held in the same way, so each sampled result depends on exactly one set of inputs.

// File: rtl/lcomp_pkg.sv
package lcomp_pkg;

  // Pixel picked by one pipe in the first stage
  typedef struct packed {
    logic        vld;
    logic [7:0]  a;
    logic [23:0] rgb;
    logic        lowest;
  } pipe_px_t;

  // Rounded 8-bit product a*b/255
  function automatic logic [7:0] scale8(input logic [7:0] a, input logic [7:0] b);
    logic [16:0] s;
    s = 17'(a) * 17'(b) + 17'd127;
    return 8'(s / 17'd255);
  endfunction

  // Rounded per-channel mix of top over bottom with weight a
  function automatic logic [7:0] mix8(input logic [7:0] a, input logic [7:0] t,
                                      input logic [7:0] b);
    logic [16:0] s;
    s = 17'(a) * 17'(t) + 17'(8'd255 - a) * 17'(b) + 17'd127;
    return 8'(s / 17'd255);
  endfunction

endpackage

// File: rtl/lcomp_layer_hit.sv
module lcomp_layer_hit #(
  parameter int COORD_W = 11
) (
  input  logic                      en,
  input  logic [COORD_W-1:0]        x,
  input  logic [COORD_W-1:0]        y,
  input  logic signed [COORD_W:0]   lx,
  input  logic signed [COORD_W:0]   ly,
  input  logic [COORD_W-1:0]        lw,
  input  logic [COORD_W-1:0]        lh,
  input  logic [7:0]                px_a,
  input  logic                      ga_en,
  input  logic [15:0]               ga,
  output logic                      hit,
  output logic [7:0]                a_eff
);
  import lcomp_pkg::*;

  localparam int EW = COORD_W + 2;

  logic signed [EW-1:0] xe, ye, lxe, lye, xend, yend;
  logic                 in_x, in_y;

  always_comb begin
    xe   = signed'({2'b00, x});
    ye   = signed'({2'b00, y});
    lxe  = signed'({lx[COORD_W], lx});
    lye  = signed'({ly[COORD_W], ly});
    xend = lxe + signed'({2'b00, lw});
    yend = lye + signed'({2'b00, lh});
    in_x = (xe >= lxe) && (xe < xend);
    in_y = (ye >= lye) && (ye < yend);
    hit  = en && in_x && in_y;
    a_eff = ga_en ? scale8(px_a, ga[15:8]) : px_a;
  end

endmodule

// File: rtl/lcomp_pipe_sel.sv
module lcomp_pipe_sel #(
  parameter int NL     = 4,
  parameter int PRIO_W = 2,
  parameter bit PIPE_ID = 1'b0
) (
  input  logic [NL-1:0]        en,
  input  logic [NL-1:0]        hit,
  input  logic [NL-1:0]        pipe,
  input  logic [NL*PRIO_W-1:0] prio,
  input  logic [NL*8-1:0]      a_eff,
  input  logic [NL*24-1:0]     rgb,
  output lcomp_pkg::pipe_px_t  px
);
  import lcomp_pkg::*;

  localparam int IDX_W = (NL > 1) ? $clog2(NL) : 1;

  logic              found, low_any;
  logic [PRIO_W-1:0] best, lowp, pr;
  logic [IDX_W-1:0]  sel_idx, low_idx;

  always_comb begin
    found   = 1'b0;
    low_any = 1'b0;
    best    = '0;
    lowp    = '1;
    sel_idx = '0;
    low_idx = '0;
    for (int i = 0; i < NL; i++) begin
      pr = prio[i*PRIO_W +: PRIO_W];
      if (en[i] && (pipe[i] == PIPE_ID)) begin
        if (!low_any || (pr <= lowp)) begin
          lowp    = pr;
          low_idx = IDX_W'(i);
          low_any = 1'b1;
        end
      end
      if (hit[i] && (pipe[i] == PIPE_ID) && (!found || (pr > best))) begin
        found   = 1'b1;
        best    = pr;
        sel_idx = IDX_W'(i);
      end
    end
    px.vld    = found;
    px.a      = a_eff[sel_idx*8 +: 8];
    px.rgb    = rgb[sel_idx*24 +: 24];
    px.lowest = found && low_any && (sel_idx == low_idx);
  end

endmodule

// File: rtl/lcomp_blend.sv
module lcomp_blend (
  input  logic        vld,
  input  logic [7:0]  a,
  input  logic [23:0] top,
  input  logic [23:0] bot,
  output logic [23:0] mix
);
  import lcomp_pkg::*;

  logic [23:0] m;

  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign m[c*8 +: 8] = mix8(a, top[c*8 +: 8], bot[c*8 +: 8]);
  end

  assign mix = vld ? m : bot;

endmodule

// File: rtl/lcomp_top.sv
module lcomp_top #(
  parameter int NL      = 4,
  parameter int COORD_W = 11,
  parameter int PRIO_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [COORD_W-1:0]       ras_x,
  input  logic [COORD_W-1:0]       ras_y,
  input  logic [23:0]              bg_rgb,
  input  logic                     low_alpha_drop,
  input  logic [NL-1:0]            lay_en,
  input  logic [NL-1:0]            lay_pipe,
  input  logic [NL*PRIO_W-1:0]     lay_prio,
  input  logic [NL-1:0]            lay_gaen,
  input  logic [NL*16-1:0]         lay_galpha,
  input  logic [NL*(COORD_W+1)-1:0] lay_xpos,
  input  logic [NL*(COORD_W+1)-1:0] lay_ypos,
  input  logic [NL*COORD_W-1:0]    lay_w,
  input  logic [NL*COORD_W-1:0]    lay_h,
  input  logic [NL*32-1:0]         lay_argb,
  output logic [23:0]              out_rgb
);
  import lcomp_pkg::*;

  localparam int PW = COORD_W + 1;

  logic [NL-1:0]    hit;
  logic [NL*8-1:0]  a_eff;
  logic [NL*24-1:0] rgb_flat;

  for (genvar i = 0; i < NL; i++) begin : g_lay
    assign rgb_flat[i*24 +: 24] = lay_argb[i*32 +: 24];
    lcomp_layer_hit #(.COORD_W(COORD_W)) u_hit (
      .en    (lay_en[i]),
      .x     (ras_x),
      .y     (ras_y),
      .lx    (signed'(lay_xpos[i*PW +: PW])),
      .ly    (signed'(lay_ypos[i*PW +: PW])),
      .lw    (lay_w[i*COORD_W +: COORD_W]),
      .lh    (lay_h[i*COORD_W +: COORD_W]),
      .px_a  (lay_argb[i*32+24 +: 8]),
      .ga_en (lay_gaen[i]),
      .ga    (lay_galpha[i*16 +: 16]),
      .hit   (hit[i]),
      .a_eff (a_eff[i*8 +: 8])
    );
  end

  pipe_px_t sel [2];

  for (genvar p = 0; p < 2; p++) begin : g_pipe
    lcomp_pipe_sel #(.NL(NL), .PRIO_W(PRIO_W), .PIPE_ID(p[0])) u_sel (
      .en    (lay_en),
      .hit   (hit),
      .pipe  (lay_pipe),
      .prio  (lay_prio),
      .a_eff (a_eff),
      .rgb   (rgb_flat),
      .px    (sel[p])
    );
  end

  // Stage 1: pipe picks plus background
  pipe_px_t    s1_p0_d, s1_p0_q, s1_p1_q;
  logic [23:0] s1_bg_q;

  always_comb begin
    s1_p0_d = sel[0];
    if (low_alpha_drop && sel[0].vld && sel[0].lowest && (sel[0].a != 8'hFF)) begin
      s1_p0_d.rgb = bg_rgb;
      s1_p0_d.a   = 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_p0_q <= '0;
      s1_p1_q <= '0;
      s1_bg_q <= '0;
    end else begin
      s1_p0_q <= s1_p0_d;
      s1_p1_q <= sel[1];
      s1_bg_q <= bg_rgb;
    end
  end

  // Stage 2: lower pipe over background, upper pipe over that
  logic [23:0] mid_rgb, fin_rgb;

  lcomp_blend u_bl_lo (
    .vld (s1_p0_q.vld), .a (s1_p0_q.a), .top (s1_p0_q.rgb), .bot (s1_bg_q), .mix (mid_rgb)
  );
  lcomp_blend u_bl_hi (
    .vld (s1_p1_q.vld), .a (s1_p1_q.a), .top (s1_p1_q.rgb), .bot (mid_rgb), .mix (fin_rgb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_rgb <= '0;
    else        out_rgb <= fin_rgb;
  end

endmodule

// File: rtl/lcomp_chk.sv
module lcomp_chk #(
  parameter int NL = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                low_alpha_drop,
  input logic [NL-1:0]       lay_en,
  input logic [NL-1:0]       lay_pipe,
  input logic [23:0]         bg_rgb,
  input logic [23:0]         out_rgb,
  input lcomp_pkg::pipe_px_t p0,
  input lcomp_pkg::pipe_px_t p1,
  input logic [23:0]         bg_q
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_RST_BLACK: assert property (@(posedge clk) !rst_n |-> (out_rgb == 24'h0)); // R9

  AST_OFF_NO_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    (lay_en == '0) |=> (!p0.vld && !p1.vld)); // R1

  AST_PIPE1_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0) && p1.vld |-> $past(|(lay_en & lay_pipe))); // R2

  AST_TOP_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (p1.vld && (p1.a == 8'hFF)) |=> (out_rgb == $past(p1.rgb))); // R6

  AST_EMPTY_BG: assert property (@(posedge clk) disable iff (!rst_n)
    (!p0.vld && !p1.vld) |=> (out_rgb == $past(bg_q))); // R7

  AST_DROP_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0) && $past(low_alpha_drop) && p0.vld && p0.lowest |-> (p0.a == 8'hFF)); // R8

  AST_LAT_BG: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) && ($past(lay_en, 1) == '0) && ($past(lay_en, 2) == '0)
      |-> (out_rgb == $past(bg_rgb, 2))); // R10

endmodule

bind lcomp_top lcomp_chk #(.NL(NL)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .low_alpha_drop (low_alpha_drop),
  .lay_en         (lay_en),
  .lay_pipe       (lay_pipe),
  .bg_rgb         (bg_rgb),
  .out_rgb        (out_rgb),
  .p0             (s1_p0_q),
  .p1             (s1_p1_q),
  .bg_q           (s1_bg_q)
);

// File: tb/lcomp_top_tb.sv
module lcomp_top_tb;

  logic         clk;
  logic         rst_n;
  logic [10:0]  ras_x, ras_y;
  logic [23:0]  bg_rgb;
  logic         low_alpha_drop;
  logic [3:0]   lay_en, lay_pipe, lay_gaen;
  logic [7:0]   lay_prio;
  logic [63:0]  lay_galpha;
  logic [47:0]  lay_xpos, lay_ypos;
  logic [43:0]  lay_w, lay_h;
  logic [127:0] lay_argb;
  logic [23:0]  out_rgb;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  lcomp_top u_dut (
    .clk (clk), .rst_n (rst_n), .ras_x (ras_x), .ras_y (ras_y), .bg_rgb (bg_rgb),
    .low_alpha_drop (low_alpha_drop), .lay_en (lay_en), .lay_pipe (lay_pipe),
    .lay_prio (lay_prio), .lay_gaen (lay_gaen), .lay_galpha (lay_galpha),
    .lay_xpos (lay_xpos), .lay_ypos (lay_ypos), .lay_w (lay_w), .lay_h (lay_h),
    .lay_argb (lay_argb), .out_rgb (out_rgb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Point table: {x, y, expected RGB} against the base scene
  localparam int NV = 12;
  localparam logic [45:0] VEC [NV] = '{
    {11'd5,   11'd5,  24'h881018},  // R6 pipe1 half alpha over pipe0
    {11'd25,  11'd25, 24'h102030},  // R4 past end of layer 2
    {11'd55,  11'd55, 24'h405060},  // R3 higher priority wins
    {11'd150, 11'd5,  24'h0A0B0C},  // R7 background
    {11'd205, 11'd5,  24'h058506},  // R5 global alpha over background
    {11'd99,  11'd99, 24'h102030},  // R4 last covered pixel
    {11'd100, 11'd5,  24'h0A0B0C},  // R4 first uncovered column
    {11'd19,  11'd19, 24'h881018},  // R4 clipped layer, last pixel
    {11'd20,  11'd20, 24'h102030},  // R4 clipped layer, first outside
    {11'd69,  11'd69, 24'h405060},  // R3 edge of layer 1
    {11'd0,   11'd0,  24'h881018},  // R4 negative position clipped
    {11'd205, 11'd15, 24'h0A0B0C}   // R4 below layer 3
  };

  task automatic set_layer(input int i, input bit en, input bit pp, input logic [1:0] pr,
                           input bit gen, input logic [15:0] ga,
                           input int x, input int y, input int w, input int h,
                           input logic [31:0] px);
    lay_en[i]               = en;
    lay_pipe[i]             = pp;
    lay_prio[i*2 +: 2]      = pr;
    lay_gaen[i]             = gen;
    lay_galpha[i*16 +: 16]  = ga;
    lay_xpos[i*12 +: 12]    = 12'(x);
    lay_ypos[i*12 +: 12]    = 12'(y);
    lay_w[i*11 +: 11]       = 11'(w);
    lay_h[i*11 +: 11]       = 11'(h);
    lay_argb[i*32 +: 32]    = px;
  endtask

  task automatic base_scene();
    bg_rgb         = 24'h0A0B0C;
    low_alpha_drop = 1'b0;
    set_layer(0, 1, 0, 2'd0, 0, 16'h0000, 0,   0,   100, 100, 32'hFF102030);
    set_layer(1, 1, 0, 2'd1, 0, 16'h0000, 50,  50,  20,  20,  32'hFF405060);
    set_layer(2, 1, 1, 2'd0, 0, 16'h0000, -10, -10, 30,  30,  32'h80FF0000);
    set_layer(3, 1, 1, 2'd2, 1, 16'h80FF, 200, 0,   10,  10,  32'hFF00FF00);
  endtask

  task automatic chk(input string req, input logic [23:0] exp);
    tests++;
    if (out_rgb !== exp) begin
      fails++;
      $display("FAIL %s: out_rgb=%06h expected=%06h", req, out_rgb, exp);
    end
  endtask

  task automatic at(input int x, input int y);
    @(negedge clk);
    ras_x = 11'(x);
    ras_y = 11'(y);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ras_x = '0;
    ras_y = '0;
    lay_en = '0; lay_pipe = '0; lay_gaen = '0; lay_prio = '0; lay_galpha = '0;
    lay_xpos = '0; lay_ypos = '0; lay_w = '0; lay_h = '0; lay_argb = '0;
    base_scene();
    repeat (3) @(negedge clk);
    chk("R9 reset output black", 24'h000000);
    rst_n = 1'b1;

    // Table walk over the base scene
    for (int k = 0; k < NV; k++) begin
      at(int'(VEC[k][45:35]), int'(VEC[k][34:24]));
      chk("R3/R4/R5/R6/R7 table point", VEC[k][23:0]);
    end

    // R10: two-edge latency
    at(150, 5);
    chk("R10 settle", 24'h0A0B0C);
    @(negedge clk);
    ras_x = 11'd25; ras_y = 11'd25;
    @(posedge clk);
    @(negedge clk);
    chk("R10 one edge still old", 24'h0A0B0C);
    @(posedge clk);
    @(negedge clk);
    chk("R10 two edges new", 24'h102030);

    // R1: disabled layers have no effect
    lay_en[1] = 1'b0;
    at(55, 55);
    chk("R1 layer 1 off", 24'h102030);
    lay_en[0] = 1'b0;
    at(25, 25);
    chk("R1 layer 0 off", 24'h0A0B0C);
    base_scene();

    // R3: equal priority -> lower index
    lay_prio[3:2] = 2'd0;
    at(55, 55);
    chk("R3 tie lower index", 24'h102030);
    base_scene();

    // R2: move layer 2 to the lower pipe with top priority
    lay_pipe[2] = 1'b0;
    lay_prio[5:4] = 2'd3;
    at(5, 5);
    chk("R2 pipe swap", 24'h850506);
    base_scene();

    // R5: global alpha off, and zero global alpha
    lay_gaen[3] = 1'b0;
    at(205, 5);
    chk("R5 global alpha off", 24'h00FF00);
    lay_gaen[3] = 1'b1;
    lay_galpha[63:48] = 16'h00FF;
    at(205, 5);
    chk("R5 zero global alpha", 24'h0A0B0C);
    base_scene();

    // R4: zero width covers nothing
    lay_w[43:33] = 11'd0;
    at(205, 5);
    chk("R4 zero width", 24'h0A0B0C);
    base_scene();

    // R8: lowest-priority pipe-0 layer with alpha
    lay_argb[31:24] = 8'h80;
    at(25, 25);
    chk("R8 flaw mode off", 24'h0D161E);
    low_alpha_drop = 1'b1;
    at(25, 25);
    chk("R8 flaw mode on", 24'h0A0B0C);
    at(55, 55);
    chk("R8 other layer unaffected", 24'h405060);
    lay_argb[31:24] = 8'hFF;
    at(25, 25);
    chk("R8 opaque lowest kept", 24'h102030);
    base_scene();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule